// File: doc/BRIEF.md
# Raster Scanout Engine

This block produces the sync timing and pixel stream for a 640x480, 60 Hz monitor from a 50 MHz system clock. A horizontal counter advances on every clock and a vertical counter advances once per line, so each displayed pixel spans two clocks. The horizontal and vertical sync levels are decoded from those two counters. Pixel data comes from an upstream word FIFO. Each 32-bit word carries four 8-bit pixels in 3:3:2 RGB. The block pops one word for every four pixels, and only while the beam is inside an active window that software can program.

The FIFO side is a valid/ready stream with one unusual rule. The block raises `fifo_ready` on the first clock of the first pixel of each group of four, and only then. It never waits for `fifo_valid`. A word is consumed when both signals are high. If `fifo_valid` is low when the block pops, those four pixels are shown black and the timing carries on unchanged. Keeping the FIFO filled in time is the job of the upstream mover.

Popped words pass through a holding register. Each word is then split into pixels, and the result goes through an output register. The sync outputs are delayed to match, so every output appears two clocks after the counter state that produced it. Window bounds are written through a plain strobe/select/data port and take effect on the next clock edge.

Top module: `raster_scanout`

## Requirements
- R1: The line is H_TOTAL clocks long (counter 0..H_TOTAL-1). `hsync` is low for counter values below H_SYNC and high for the rest of the line.
- R2: The frame is V_TOTAL lines long. The line counter steps when the clock counter wraps. `vsync` is low only on lines below V_SYNC.
- R3: Pixel x is the clock count divided by 2, and the line is y. A pixel is inside the window when x_start <= x < x_end and y_start <= y < y_end. `fifo_ready` is high for exactly one clock: the even clock of each in-window pixel whose offset (x - x_start) is a multiple of 4. It is never high at any other time.
- R4: The pixel at offset k shows byte (k mod 4) of the word popped for its group, bits [8(k mod 4)+7 : 8(k mod 4)]. The low byte is shown first, and each pixel is held for two clocks.
- R5: Pixels outside the window are driven as all-zero RGB.
- R6: If `fifo_valid` is low on a popping clock, the four pixels of that group are black. Timing and later pops are unaffected.
- R7: `hsync`, `vsync` and RGB all appear two clocks after the counter state that produced them.
- R8: `cfg_sel` selects the bound to write: 0 = x_start, 1 = x_end, 2 = y_start, 3 = y_end. A write happens on a clock with `cfg_we` high. Reset loads the X_START, X_END, Y_START and Y_END parameters, which by default cover the visible 640x480 area.
- R9: During reset, `hsync`, `vsync`, `fifo_ready` and all RGB outputs are low.
- R10: Pixel byte bits [7:5] drive `red`, bits [4:2] drive `green` and bits [1:0] drive `blue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (two clocks per pixel) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window bound write strobe |
| cfg_sel | input | 2 | Bound select (0 x_start, 1 x_end, 2 y_start, 3 y_end) |
| cfg_data | input | CW | Bound value in pixel or line units |
| fifo_data | input | WORD_W | Four packed pixels, low byte first |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_ready | output | 1 | Pop strobe |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| red | output | RED_W | Red component |
| green | output | GRN_W | Green component |
| blue | output | BLU_W | Blue component |

## Verification
The bench uses a reduced timing (40-clock lines, 8-line frames) and compares every output on every clock of several whole frames. The window is set in turn to:
- the reset default;
- a width that is not a multiple of four, which shows whether a trailing partial word is still popped;
- the full raster, including the sync region, which separates window gating from sync decode;
- an empty window, which must never pop;
- a single word on a single line, which checks the boundary comparisons.

A starved run drops `fifo_valid` on every other word, so black groups appear among correct ones. This shows whether underrun handling leaks into neighbouring groups or shifts the timing. Per-frame pop counts give an arithmetic cross-check on the window bounds.

// File: rtl/raster_scanout_pkg.sv
package raster_scanout_pkg;

  typedef enum logic [1:0] {
    BND_X_START = 2'd0,
    BND_X_END   = 2'd1,
    BND_Y_START = 2'd2,
    BND_Y_END   = 2'd3
  } bound_sel_e;

  localparam int NUM_BOUNDS = 4;

  typedef struct packed {
    logic hs;
    logic vs;
    logic act;
  } beam_flags_t;

endpackage

// File: rtl/beam_counter.sv
module beam_counter #(
  parameter int H_TOTAL = 1600,
  parameter int H_SYNC  = 190,
  parameter int V_TOTAL = 521,
  parameter int V_SYNC  = 1,
  parameter int HW      = 11,
  parameter int VW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          hs_lvl,
  output logic          vs_lvl
);

  logic h_last;
  logic v_last;

  assign h_last = (hcnt == HW'(H_TOTAL - 1));
  assign v_last = (vcnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  assign hs_lvl = (hcnt >= HW'(H_SYNC));
  assign vs_lvl = (vcnt >= VW'(V_SYNC));

endmodule

// File: rtl/window_gate.sv
module window_gate
  import raster_scanout_pkg::*;
#(
  parameter int XW      = 10,
  parameter int VW      = 10,
  parameter int CW      = 10,
  parameter int LW      = 2,
  parameter int X_START = 144,
  parameter int X_END   = 784,
  parameter int Y_START = 31,
  parameter int Y_END   = 511
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  input  logic [XW-1:0] pix_x,
  input  logic [VW-1:0] line_y,
  input  logic          half,
  output logic          active,
  output logic [LW-1:0] lane,
  output logic          fetch
);

  logic [CW-1:0] bound_q [NUM_BOUNDS];

  function automatic logic [CW-1:0] bound_reset(input int idx);
    case (idx)
      0:       return CW'(X_START);
      1:       return CW'(X_END);
      2:       return CW'(Y_START);
      default: return CW'(Y_END);
    endcase
  endfunction

  for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_bound
    localparam bound_sel_e FIELD = bound_sel_e'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bound_q[i] <= bound_reset(i);
      end else if (cfg_we && (cfg_sel == FIELD)) begin
        bound_q[i] <= cfg_data;
      end
    end
  end

  logic [CW-1:0] xe;
  logic [CW-1:0] ye;
  logic in_x;
  logic in_y;

  assign xe   = CW'(pix_x);
  assign ye   = CW'(line_y);
  assign in_x = (xe >= bound_q[int'(BND_X_START)]) && (xe < bound_q[int'(BND_X_END)]);
  assign in_y = (ye >= bound_q[int'(BND_Y_START)]) && (ye < bound_q[int'(BND_Y_END)]);

  assign active = in_x && in_y;
  assign lane   = LW'(pix_x) - LW'(bound_q[int'(BND_X_START)]);
  assign fetch  = active && !half && (lane == '0);

endmodule

// File: rtl/pixel_unpack.sv
module pixel_unpack
  import raster_scanout_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RED_W  = 3,
  parameter int GRN_W  = 3,
  parameter int BLU_W  = 2,
  parameter int LW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic              fifo_valid,
  input  logic [WORD_W-1:0] fifo_data,
  input  beam_flags_t       flags_in,
  input  logic [LW-1:0]     lane_in,
  output logic              hsync,
  output logic              vsync,
  output logic [RED_W-1:0]  red,
  output logic [GRN_W-1:0]  green,
  output logic [BLU_W-1:0]  blue
);

  localparam int BPP   = RED_W + GRN_W + BLU_W;
  localparam int LANES = WORD_W / BPP;

  logic [WORD_W-1:0] word_q;
  beam_flags_t       flags_q;
  logic [LW-1:0]     lane_q;
  logic [BPP-1:0]    lanes [LANES];
  logic [BPP-1:0]    pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      flags_q <= '0;
      lane_q  <= '0;
    end else begin
      flags_q <= flags_in;
      lane_q  <= lane_in;
      if (fetch) begin
        word_q <= fifo_valid ? fifo_data : '0;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = word_q[i*BPP +: BPP];
  end

  assign pix = flags_q.act ? lanes[lane_q] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      red   <= '0;
      green <= '0;
      blue  <= '0;
    end else begin
      hsync <= flags_q.hs;
      vsync <= flags_q.vs;
      red   <= pix[BPP-1 -: RED_W];
      green <= pix[BLU_W+GRN_W-1 -: GRN_W];
      blue  <= pix[BLU_W-1:0];
    end
  end

endmodule

// File: rtl/raster_scanout.sv
module raster_scanout
  import raster_scanout_pkg::*;
#(
  parameter int H_TOTAL = 1600,
  parameter int H_SYNC  = 190,
  parameter int V_TOTAL = 521,
  parameter int V_SYNC  = 1,
  parameter int X_START = 144,
  parameter int X_END   = 784,
  parameter int Y_START = 31,
  parameter int Y_END   = 511,
  parameter int WORD_W  = 32,
  parameter int RED_W   = 3,
  parameter int GRN_W   = 3,
  parameter int BLU_W   = 2,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int XW = HW - 1,
  localparam int CW = (XW > VW) ? XW : VW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CW-1:0]     cfg_data,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic              hsync,
  output logic              vsync,
  output logic [RED_W-1:0]  red,
  output logic [GRN_W-1:0]  green,
  output logic [BLU_W-1:0]  blue
);

  localparam int BPP   = RED_W + GRN_W + BLU_W;
  localparam int LANES = WORD_W / BPP;
  localparam int LW    = $clog2(LANES);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hs_lvl;
  logic          vs_lvl;
  logic          active;
  logic [LW-1:0] lane;
  logic          fetch;
  beam_flags_t   flags;

  beam_counter #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .V_TOTAL(V_TOTAL), .V_SYNC(V_SYNC),
    .HW(HW), .VW(VW)
  ) u_beam (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .hs_lvl(hs_lvl), .vs_lvl(vs_lvl)
  );

  window_gate #(
    .XW(XW), .VW(VW), .CW(CW), .LW(LW),
    .X_START(X_START), .X_END(X_END), .Y_START(Y_START), .Y_END(Y_END)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pix_x(hcnt[HW-1:1]), .line_y(vcnt), .half(hcnt[0]),
    .active(active), .lane(lane), .fetch(fetch)
  );

  assign flags      = '{hs: hs_lvl, vs: vs_lvl, act: active};
  assign fifo_ready = fetch;

  pixel_unpack #(
    .WORD_W(WORD_W), .RED_W(RED_W), .GRN_W(GRN_W), .BLU_W(BLU_W), .LW(LW)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .flags_in(flags), .lane_in(lane),
    .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
  );

endmodule

// File: rtl/raster_scanout_chk.sv
module raster_scanout_chk #(
  parameter int H_TOTAL = 1600,
  parameter int H_SYNC  = 190,
  parameter int V_TOTAL = 521,
  parameter int V_SYNC  = 1,
  parameter int HW      = 11,
  parameter int VW      = 10,
  parameter int RED_W   = 3,
  parameter int GRN_W   = 3,
  parameter int BLU_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [HW-1:0]    hcnt,
  input logic [VW-1:0]    vcnt,
  input logic             fifo_ready,
  input logic             fifo_valid,
  input logic             hsync,
  input logic             vsync,
  input logic [RED_W-1:0] red,
  input logic [GRN_W-1:0] green,
  input logic [BLU_W-1:0] blue
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r1_hcnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HW'(H_TOTAL - 1)) |=> (hcnt == '0));

  a_r1_hcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HW'(H_TOTAL - 1)) |=> (hcnt == $past(hcnt) + HW'(1)));

  a_r2_vcnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HW'(H_TOTAL - 1)) |=> $stable(vcnt));

  a_r2_vcnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HW'(H_TOTAL - 1) && vcnt == VW'(V_TOTAL - 1)) |=> (vcnt == '0));

  a_r7_hsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (hsync == ($past(hcnt, 2) >= HW'(H_SYNC))));

  a_r7_vsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (vsync == ($past(vcnt, 2) >= VW'(V_SYNC))));

  a_r3_pop_even_clock: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> !hcnt[0]);

  a_r3_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |=> !fifo_ready);

  a_r6_underrun_black: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && !fifo_valid) |-> ##2 ({red, green, blue} == '0));

endmodule

bind raster_scanout raster_scanout_chk #(
  .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .V_TOTAL(V_TOTAL), .V_SYNC(V_SYNC),
  .HW(HW), .VW(VW), .RED_W(RED_W), .GRN_W(GRN_W), .BLU_W(BLU_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
  .fifo_ready(fifo_ready), .fifo_valid(fifo_valid),
  .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
);

// File: tb/raster_scanout_tb.sv
module raster_scanout_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HT = 40;
  localparam int HS = 6;
  localparam int VT = 8;
  localparam int VS = 1;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_data = '0;
  logic [31:0] fifo_data = '0;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready;
  logic        hsync;
  logic        vsync;
  logic [2:0]  red;
  logic [2:0]  green;
  logic [1:0]  blue;

  raster_scanout #(
    .H_TOTAL(HT), .H_SYNC(HS), .V_TOTAL(VT), .V_SYNC(VS),
    .X_START(4), .X_END(16), .Y_START(2), .Y_END(7)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .hsync(hsync), .vsync(vsync),
    .red(red), .green(green), .blue(blue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int bh = 0, bv = 0;
  int xs = 4, xe = 16, ys = 2, ye = 7;
  bit starve = 0;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;
  logic [7:0] d1_rgb = '0, d2_rgb = '0;
  bit d1_hs = 0, d2_hs = 0, d1_vs = 0, d2_vs = 0;
  int d1_cat = 0, d2_cat = 0;

  function automatic logic [7:0] pat(int v, int w, int b);
    return 8'(v * 32 + w * 6 + b + 1);
  endfunction

  function automatic bit word_ok(int w);
    return !(starve && (w % 2 == 1));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (line %0d clk %0d)", tag, act, exp, bv, bh);
    end
  endtask

  task automatic step(bit chk);
    int x, k, w, b;
    bit inwin, rdy_exp;
    logic [7:0] cur;
    int cat;
    logic [7:0] got;
    x = bh / 2;
    inwin = (x >= xs) && (x < xe) && (bv >= ys) && (bv < ye);
    k = x - xs;
    w = (k >= 0) ? k / 4 : 0;
    b = (k >= 0) ? k % 4 : 0;
    rdy_exp = inwin && (bh % 2 == 0) && (b == 0);
    cur = '0;
    cat = 0;
    if (inwin) begin
      if (word_ok(w)) begin cur = pat(bv, w, b); cat = 1; end
      else cat = 2;
    end
    got = {red, green, blue};
    if (chk) begin
      check(hsync == d2_hs, "R1 R7 hsync", int'(hsync), int'(d2_hs));
      check(vsync == d2_vs, "R2 R7 vsync", int'(vsync), int'(d2_vs));
      check(fifo_ready == rdy_exp, "R3 fifo_ready", int'(fifo_ready), int'(rdy_exp));
      case (d2_cat)
        0: check(got == d2_rgb, "R5 outside window black", int'(got), int'(d2_rgb));
        1: check(got == d2_rgb, "R4 lane order", int'(got), int'(d2_rgb));
        default: check(got == d2_rgb, "R6 underrun black", int'(got), int'(d2_rgb));
      endcase
      if (d2_cat == 1) begin
        check(red == d2_rgb[7:5], "R10 red field", int'(red), int'(d2_rgb[7:5]));
        check(blue == d2_rgb[1:0], "R10 blue field", int'(blue), int'(d2_rgb[1:0]));
      end
    end
    if (fifo_ready) pulses++;
    fifo_data  = {pat(bv, w, 3), pat(bv, w, 2), pat(bv, w, 1), pat(bv, w, 0)};
    fifo_valid = word_ok(w);
    d2_rgb = d1_rgb; d2_hs = d1_hs; d2_vs = d1_vs; d2_cat = d1_cat;
    d1_rgb = cur;    d1_hs = (bh >= HS); d1_vs = (bv >= VS); d1_cat = cat;
    @(negedge clk);
    bh++;
    if (bh == HT) begin
      bh = 0;
      bv++;
      if (bv == VT) bv = 0;
    end
  endtask

  task automatic run_frame(bit chk);
    int words, lines;
    pulses = 0;
    repeat (FRAME) step(chk);
    words = (xe > xs) ? (xe - xs + 3) / 4 : 0;
    lines = (ye > ys) ? ((ye > VT ? VT : ye) - ys) : 0;
    if (chk) check(pulses == words * lines, "R8 pops per frame", pulses, words * lines);
  endtask

  task automatic set_win(int nxs, int nxe, int nys, int nye, bit nst);
    int vals[4];
    vals[0] = nxs; vals[1] = nxe; vals[2] = nys; vals[3] = nye;
    xs = nxs; xe = nxe; ys = nys; ye = nye; starve = nst;
    for (int i = 0; i < 4; i++) begin
      cfg_we = 1'b1;
      cfg_sel = 2'(i);
      cfg_data = 5'(vals[i]);
      step(0);
    end
    cfg_we = 1'b0;
    repeat (FRAME - 4) step(0);
    run_frame(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(hsync == 1'b0, "R9 hsync in reset", int'(hsync), 0);
    check(vsync == 1'b0, "R9 vsync in reset", int'(vsync), 0);
    check(fifo_ready == 1'b0, "R9 fifo_ready in reset", int'(fifo_ready), 0);
    check({red, green, blue} == 8'h00, "R9 rgb in reset", int'({red, green, blue}), 0);
    rst_n = 1'b1;
    bh = 0;
    bv = 0;
    run_frame(1);              // R8 reset default window
    run_frame(1);
    set_win(5, 14, 1, 8, 0);   // partial trailing word
    set_win(0, 20, 0, 8, 0);   // whole raster including sync region
    set_win(6, 6, 2, 7, 0);    // empty window: no pops
    set_win(4, 16, 2, 7, 1);   // R6 starved odd words
    set_win(3, 7, 5, 6, 0);    // single word on a single line
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

endmodule